// File: doc/BRIEF.md
# Power-Loss Checkpoint and Resume Controller

This controller sits next to a small 32-bit core (100 MHz class) that may only run while an external energy-good signal is high. When that signal falls, the controller holds the core, waits until it reports that no instruction is in flight, and copies the program counter and registers x1 to x31 into a word-wide non-volatile memory. The image is closed by a commit word. Once the image is complete, the controller turns off the core's clock enable, so the core stops switching.

When energy comes back, or at power-on, the controller first reads the commit word. If the word holds the expected magic value, it loads the saved PC and registers back into the core and then releases the stall. The core resumes at the interrupted instruction, and software cannot tell that anything happened. If the commit word is wrong, the controller pulses a cold reset into the core instead. The energy-good input is treated as asynchronous and passes through a synchronizer. The memory port moves one word per request/acknowledge handshake.

Top module: `ckpt_resume_ctrl`

## Requirements
- R1: After reset the controller is in GATED (`ctrl_state` = 3). In this state `core_clk_en` is 0, `core_stall` is 1 and `nv_req` is 0. It stays there while `energy_ok` is low.
- R2: `energy_ok` passes through SYNC_STAGES (default 2) flops. Suppose it falls while the controller is in RUN (0), where `core_stall`=0 and `core_clk_en`=1. Then the state is still RUN after two clock edges and is STALL (1) after the third. STALL sets `core_stall`=1 and keeps `core_clk_en`=1.
- R3: In STALL no memory request is made until `core_idle` is sampled high. The state then becomes SAVE (2) on that edge.
- R4: A save writes 34 words at `nv_addr` = IMG_BASE + offset, in this order: 0 to offset 32, the PC to offset 0, registers x1 to x31 to offsets 1 to 31, and last the magic value (default 0xA5C31E7D) to offset 32. Register x0 is never saved.
- R5: While `nv_req` is high and `nv_ack` is low, `nv_addr` and `nv_we` hold steady. Each cycle with both high completes exactly one word.
- R6: The cycle after the magic word is acknowledged, the state is GATED and `core_clk_en` is 0. It stays GATED while energy is absent.
- R7: In GATED with energy present, the state becomes RESTORE (4). The first read is offset 32. If that word equals the magic value, offsets 0 to 31 are read in order. Each word is loaded into the core as it is acknowledged: `pc_load` for offset 0, and `rf_we` with `rf_addr`=offset for the others. A full restore performs 33 reads.
- R8: If the commit word read differs from the magic value, no further reads happen. `core_cold_rst` is high for the single RELEASE cycle.
- R9: Once STALL has been entered, a rise of `energy_ok` does not abort the save. The commit word is written before RESTORE is entered.
- R10: After a restore, one RELEASE (5) cycle is followed by RUN. The core's PC and x1 to x31 then equal their values at the start of the save.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running clock |
| rst | input | 1 | Synchronous active-high reset |
| energy_ok | input | 1 | Asynchronous energy-available indication |
| core_idle | input | 1 | Core reports no instruction in flight |
| core_stall | output | 1 | Hold the core at an instruction boundary |
| core_clk_en | output | 1 | Core clock-gate enable |
| core_cold_rst | output | 1 | One-cycle cold reset request to the core |
| pc_rdata | input | XLEN | Current core PC |
| pc_load | output | 1 | Load `pc_wdata` into the core PC |
| pc_wdata | output | XLEN | PC value to load |
| rf_addr | output | log2(NREGS) | Register-file index for read or write |
| rf_rdata | input | XLEN | Register-file read data |
| rf_we | output | 1 | Register-file write strobe |
| rf_wdata | output | XLEN | Register-file write data |
| nv_req | output | 1 | Non-volatile memory request |
| nv_we | output | 1 | 1 = write, 0 = read |
| nv_addr | output | NV_AW | Word address |
| nv_wdata | output | XLEN | Write data |
| nv_ack | input | 1 | Word accepted / read data valid |
| nv_rdata | input | XLEN | Read data, valid with `nv_ack` |
| ctrl_state | output | 3 | Sequencer state code |

## Verification
A wrong sequencer state shows up at the very next memory handshake. The address falls out of the expected 34-word write order or 33-word read order, or a request appears before `core_idle`. These errors are caught on the edge where the word completes. A step counter that is off by one shows up as an image whose words are shifted. A stuck cold flag shows up as a spurious or missing `core_cold_rst` pulse in RELEASE. Both are detected once the restore finishes and the core's registers are compared with the snapshot taken when the save began. Synchronizer latency is checked cycle-exactly on every energy drop.

// File: rtl/ckpt_pkg.sv
package ckpt_pkg;

    typedef enum logic [2:0] {
        ST_RUN     = 3'd0,
        ST_STALL   = 3'd1,
        ST_SAVE    = 3'd2,
        ST_GATED   = 3'd3,
        ST_RESTORE = 3'd4,
        ST_RELEASE = 3'd5
    } ckpt_state_e;

    typedef struct packed {
        ckpt_state_e st;
        logic        cold;
    } seq_status_t;

    typedef enum logic [1:0] {
        SRC_ZERO  = 2'd0,
        SRC_PC    = 2'd1,
        SRC_REG   = 2'd2,
        SRC_MAGIC = 2'd3
    } word_src_e;

    // Image offset touched at a given step: the commit slot sits at the end,
    // and the PC and registers fill the slots below it.
    function automatic int unsigned img_offset(int unsigned step, int unsigned nregs);
        if (step == 0 || step > nregs) return nregs;
        return step - 1;
    endfunction

    // Source of the word written at a given save step.
    function automatic word_src_e save_src(int unsigned step, int unsigned nregs);
        if (step == 0)     return SRC_ZERO;
        if (step == 1)     return SRC_PC;
        if (step <= nregs) return SRC_REG;
        return SRC_MAGIC;
    endfunction

endpackage

// File: rtl/ckpt_sync.sv
module ckpt_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic din,
    output logic dout
);
    logic [STAGES-1:0] chain;

    for (genvar i = 0; i < STAGES; i++) begin : g_stage
        if (i == 0) begin : g_first
            always_ff @(posedge clk) begin
                if (rst) chain[i] <= 1'b0;
                else     chain[i] <= din;
            end
        end else begin : g_next
            always_ff @(posedge clk) begin
                if (rst) chain[i] <= 1'b0;
                else     chain[i] <= chain[i-1];
            end
        end
    end

    assign dout = chain[STAGES-1];
endmodule

// File: rtl/ckpt_seq.sv
module ckpt_seq
    import ckpt_pkg::*;
#(
    parameter int unsigned    XLEN  = 32,
    parameter int unsigned    NREGS = 32,
    parameter int unsigned    SW    = 6,
    parameter logic [XLEN-1:0] MAGIC = 32'hA5C3_1E7D
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            energy_good,
    input  logic            core_idle,
    input  logic            nv_ack,
    input  logic [XLEN-1:0] nv_rdata,
    output seq_status_t     status,
    output logic [SW-1:0]   step
);
    localparam logic [SW-1:0] LAST_SAVE = SW'(NREGS + 1);
    localparam logic [SW-1:0] LAST_LOAD = SW'(NREGS);

    ckpt_state_e   state_q, state_d;
    logic [SW-1:0] step_q;
    logic          cold_q;
    logic          word_done;
    logic          commit_bad;

    assign word_done  = nv_ack && (state_q == ST_SAVE || state_q == ST_RESTORE);
    assign commit_bad = (state_q == ST_RESTORE) && nv_ack && (step_q == '0)
                        && (nv_rdata != MAGIC);

    always_comb begin
        state_d = state_q;
        case (state_q)
            ST_RUN:     if (!energy_good) state_d = ST_STALL;
            ST_STALL:   if (core_idle) state_d = ST_SAVE;
            ST_SAVE:    if (nv_ack && step_q == LAST_SAVE) state_d = ST_GATED;
            ST_GATED:   if (energy_good) state_d = ST_RESTORE;
            ST_RESTORE: if (commit_bad || (nv_ack && step_q == LAST_LOAD)) state_d = ST_RELEASE;
            ST_RELEASE: state_d = ST_RUN;
            default:    state_d = ST_GATED;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_GATED;
            step_q  <= '0;
            cold_q  <= 1'b0;
        end else begin
            state_q <= state_d;
            if (state_d != state_q) step_q <= '0;
            else if (word_done)     step_q <= step_q + 1'b1;
            if (state_q == ST_GATED && state_d == ST_RESTORE) cold_q <= 1'b0;
            else if (commit_bad)                              cold_q <= 1'b1;
        end
    end

    assign status.st   = state_q;
    assign status.cold = cold_q;
    assign step        = step_q;

    AST_WAIT_IDLE: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_STALL && !core_idle) |=> (state_q == ST_STALL)); // R3

    AST_SAVE_NO_ABORT: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_SAVE && !(nv_ack && step_q == LAST_SAVE)) |=> (state_q == ST_SAVE)); // R9

    AST_COMMIT_THEN_GATE: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_SAVE && nv_ack && step_q == LAST_SAVE) |=> (state_q == ST_GATED)); // R6

    AST_RELEASE_ONE: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_RELEASE) |=> (state_q == ST_RUN)); // R10
endmodule

// File: rtl/ckpt_dpath.sv
module ckpt_dpath
    import ckpt_pkg::*;
#(
    parameter int unsigned    XLEN     = 32,
    parameter int unsigned    NREGS    = 32,
    parameter int unsigned    SW       = 6,
    parameter int unsigned    AW       = 6,
    parameter int unsigned    RAW      = 5,
    parameter int unsigned    IMG_BASE = 0,
    parameter logic [XLEN-1:0] MAGIC   = 32'hA5C3_1E7D
) (
    input  seq_status_t     status,
    input  logic [SW-1:0]   step,
    input  logic            nv_ack,
    input  logic [XLEN-1:0] nv_rdata,
    input  logic [XLEN-1:0] rf_rdata,
    input  logic [XLEN-1:0] pc_rdata,
    output logic            nv_req,
    output logic            nv_we,
    output logic [AW-1:0]   nv_addr,
    output logic [XLEN-1:0] nv_wdata,
    output logic [RAW-1:0]  rf_addr,
    output logic            rf_we,
    output logic [XLEN-1:0] rf_wdata,
    output logic            pc_load,
    output logic [XLEN-1:0] pc_wdata,
    output logic            core_stall,
    output logic            core_clk_en,
    output logic            core_cold_rst
);
    localparam logic [SW-1:0] STEP_PC   = SW'(1);
    localparam logic [SW-1:0] STEP_REG0 = SW'(2);
    localparam logic [SW-1:0] STEP_REGN = SW'(NREGS);

    logic        in_save, in_load;
    int unsigned offset;
    word_src_e   src;

    assign in_save = (status.st == ST_SAVE);
    assign in_load = (status.st == ST_RESTORE);
    assign offset  = img_offset(32'(step), NREGS);
    assign src     = save_src(32'(step), NREGS);

    assign nv_req  = in_save || in_load;
    assign nv_we   = in_save;
    assign nv_addr = AW'(IMG_BASE + offset);
    assign rf_addr = RAW'(offset);

    always_comb begin
        case (src)
            SRC_ZERO:  nv_wdata = '0;
            SRC_PC:    nv_wdata = pc_rdata;
            SRC_REG:   nv_wdata = rf_rdata;
            default:   nv_wdata = MAGIC;
        endcase
    end

    assign pc_load  = in_load && nv_ack && (step == STEP_PC);
    assign rf_we    = in_load && nv_ack && (step >= STEP_REG0) && (step <= STEP_REGN);
    assign pc_wdata = nv_rdata;
    assign rf_wdata = nv_rdata;

    assign core_stall    = (status.st != ST_RUN);
    assign core_clk_en   = (status.st != ST_GATED);
    assign core_cold_rst = (status.st == ST_RELEASE) && status.cold;
endmodule

// File: rtl/ckpt_resume_ctrl.sv
module ckpt_resume_ctrl
    import ckpt_pkg::*;
#(
    parameter int unsigned    XLEN        = 32,
    parameter int unsigned    NREGS       = 32,
    parameter int unsigned    NV_AW       = 6,
    parameter int unsigned    IMG_BASE    = 0,
    parameter int unsigned    SYNC_STAGES = 2,
    parameter logic [XLEN-1:0] MAGIC      = 32'hA5C3_1E7D
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     energy_ok,
    input  logic                     core_idle,
    output logic                     core_stall,
    output logic                     core_clk_en,
    output logic                     core_cold_rst,
    input  logic [XLEN-1:0]          pc_rdata,
    output logic                     pc_load,
    output logic [XLEN-1:0]          pc_wdata,
    output logic [$clog2(NREGS)-1:0] rf_addr,
    input  logic [XLEN-1:0]          rf_rdata,
    output logic                     rf_we,
    output logic [XLEN-1:0]          rf_wdata,
    output logic                     nv_req,
    output logic                     nv_we,
    output logic [NV_AW-1:0]         nv_addr,
    output logic [XLEN-1:0]          nv_wdata,
    input  logic                     nv_ack,
    input  logic [XLEN-1:0]          nv_rdata,
    output logic [2:0]               ctrl_state
);
    localparam int unsigned SW  = $clog2(NREGS + 2);
    localparam int unsigned RAW = $clog2(NREGS);

    logic          energy_good;
    seq_status_t   status;
    logic [SW-1:0] step;

    ckpt_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst(rst), .din(energy_ok), .dout(energy_good)
    );

    ckpt_seq #(.XLEN(XLEN), .NREGS(NREGS), .SW(SW), .MAGIC(MAGIC)) u_seq (
        .clk(clk), .rst(rst), .energy_good(energy_good), .core_idle(core_idle),
        .nv_ack(nv_ack), .nv_rdata(nv_rdata), .status(status), .step(step)
    );

    ckpt_dpath #(.XLEN(XLEN), .NREGS(NREGS), .SW(SW), .AW(NV_AW), .RAW(RAW),
                 .IMG_BASE(IMG_BASE), .MAGIC(MAGIC)) u_dpath (
        .status(status), .step(step), .nv_ack(nv_ack), .nv_rdata(nv_rdata),
        .rf_rdata(rf_rdata), .pc_rdata(pc_rdata),
        .nv_req(nv_req), .nv_we(nv_we), .nv_addr(nv_addr), .nv_wdata(nv_wdata),
        .rf_addr(rf_addr), .rf_we(rf_we), .rf_wdata(rf_wdata),
        .pc_load(pc_load), .pc_wdata(pc_wdata),
        .core_stall(core_stall), .core_clk_en(core_clk_en), .core_cold_rst(core_cold_rst)
    );

    assign ctrl_state = status.st;

    AST_REQ_HOLD: assert property (@(posedge clk) disable iff (rst)
        (nv_req && !nv_ack) |=> (nv_req && $stable(nv_addr) && $stable(nv_we))); // R5

    AST_COLD_IN_RELEASE: assert property (@(posedge clk) disable iff (rst)
        core_cold_rst |-> (ctrl_state == ST_RELEASE)); // R8

    AST_GATED_QUIET: assert property (@(posedge clk) disable iff (rst)
        !core_clk_en |-> (!nv_req && core_stall)); // R6

    AST_LOAD_STALLED: assert property (@(posedge clk) disable iff (rst)
        (rf_we || pc_load) |-> (core_stall && !nv_we && core_clk_en)); // R7

    AST_NO_X0_WRITE: assert property (@(posedge clk) disable iff (rst)
        rf_we |-> (rf_addr != '0)); // R4
endmodule

// File: tb/tb_ckpt_resume_ctrl.sv
`timescale 1ns/1ps
module tb_ckpt_resume_ctrl;
    localparam logic [31:0] MAGIC = 32'hA5C3_1E7D;
    localparam logic [2:0] S_RUN = 3'd0, S_STALL = 3'd1, S_SAVE = 3'd2,
                           S_GATED = 3'd3, S_RESTORE = 3'd4;

    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic        rst, energy_ok, core_idle;
    logic        core_stall, core_clk_en, core_cold_rst;
    logic [31:0] pc_rdata, pc_wdata, rf_rdata, rf_wdata, nv_wdata, nv_rdata;
    logic        pc_load, rf_we, nv_req, nv_we, nv_ack;
    logic [4:0]  rf_addr;
    logic [5:0]  nv_addr;
    logic [2:0]  ctrl_state;

    ckpt_resume_ctrl dut (
        .clk(clk), .rst(rst), .energy_ok(energy_ok), .core_idle(core_idle),
        .core_stall(core_stall), .core_clk_en(core_clk_en), .core_cold_rst(core_cold_rst),
        .pc_rdata(pc_rdata), .pc_load(pc_load), .pc_wdata(pc_wdata),
        .rf_addr(rf_addr), .rf_rdata(rf_rdata), .rf_we(rf_we), .rf_wdata(rf_wdata),
        .nv_req(nv_req), .nv_we(nv_we), .nv_addr(nv_addr), .nv_wdata(nv_wdata),
        .nv_ack(nv_ack), .nv_rdata(nv_rdata), .ctrl_state(ctrl_state)
    );

    // ---------------- core model ----------------
    logic [31:0] regs_m [32];
    logic [31:0] pc_m;
    logic        scr_req, cor_req;
    int unsigned r_pick;
    assign rf_rdata = regs_m[rf_addr];
    assign pc_rdata = pc_m;

    always @(posedge clk) begin
        if (rst) begin
            pc_m <= 32'h100;
            for (int i = 0; i < 32; i++) regs_m[i] <= 32'(i * 3);
        end else if (scr_req) begin
            pc_m <= $urandom;
            for (int i = 1; i < 32; i++) regs_m[i] <= $urandom;
        end else if (core_clk_en) begin
            if (core_cold_rst) begin
                pc_m <= '0;
                for (int i = 0; i < 32; i++) regs_m[i] <= '0;
            end else begin
                if (pc_load) pc_m <= pc_wdata;
                if (rf_we && rf_addr != 0) regs_m[rf_addr] <= rf_wdata;
                if (!core_stall) begin
                    pc_m <= pc_m + 32'd4;
                    r_pick = $urandom % 32;
                    if (r_pick != 0) regs_m[r_pick] <= $urandom;
                end
            end
        end
    end

    // ---------------- memory model ----------------
    logic [31:0] mem [64];
    int unsigned lat;
    assign nv_rdata = mem[nv_addr];

    always @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < 64; i++) mem[i] <= '0;
        end else if (cor_req) begin
            mem[32] <= 32'h0BAD_0001;
        end else if (nv_req && nv_ack && nv_we) begin
            mem[nv_addr] <= nv_wdata;
        end
    end

    always @(negedge clk) begin
        if (rst || !nv_req) begin
            nv_ack <= 1'b0;
            lat    <= $urandom % 4;
        end else if (nv_ack) begin
            lat    = $urandom % 4;
            nv_ack <= (lat == 0);
        end else begin
            if (lat != 0) lat = lat - 1;
            nv_ack <= (lat == 0);
        end
    end

    // ---------------- bench functions ----------------
    function automatic logic [5:0] exp_save_off(int unsigned w);
        if (w == 0 || w == 33) return 6'd32;
        return 6'(w - 1);
    endfunction

    function automatic logic [5:0] exp_load_off(int unsigned w);
        if (w == 0) return 6'd32;
        return 6'(w - 1);
    endfunction

    // ---------------- handshake monitor ----------------
    int unsigned widx, ridx, rd_total;
    int          mon_chk, mon_fail;
    logic        cold_seen, hold_pend;
    logic [5:0]  hold_addr;
    logic        hold_we;

    always @(posedge clk) begin
        if (rst) begin
            widx = 0; ridx = 0; rd_total = 0; cold_seen = 0;
            mon_chk = 0; mon_fail = 0; hold_pend = 0;
        end else begin
            if (hold_pend && nv_req) begin
                mon_chk++;
                if (nv_addr != hold_addr || nv_we != hold_we) begin
                    mon_fail++;
                    $display("FAIL R5 held request moved: addr %0d expected %0d", nv_addr, hold_addr);
                end
            end
            hold_pend = nv_req && !nv_ack;
            hold_addr = nv_addr;
            hold_we   = nv_we;
            if (ctrl_state != S_SAVE) widx = 0;
            if (ctrl_state != S_RESTORE) ridx = 0;
            if (ctrl_state == S_GATED) begin rd_total = 0; cold_seen = 0; end
            if (core_cold_rst) cold_seen = 1;
            if (nv_req && nv_ack && nv_we) begin
                mon_chk++;
                if (nv_addr != exp_save_off(widx) ||
                    (widx == 0 && nv_wdata != 0) || (widx == 33 && nv_wdata != MAGIC)) begin
                    mon_fail++;
                    $display("FAIL R4 write %0d: addr %0d data %h, expected addr %0d",
                             widx, nv_addr, nv_wdata, exp_save_off(widx));
                end
                widx++;
            end
            if (nv_req && nv_ack && !nv_we) begin
                mon_chk++;
                if (nv_addr != exp_load_off(ridx)) begin
                    mon_fail++;
                    $display("FAIL R7 read %0d: addr %0d expected %0d", ridx, nv_addr, exp_load_off(ridx));
                end
                ridx++;
                rd_total++;
            end
        end
    end

    // ---------------- checking ----------------
    int          n_chk = 0, n_fail = 0, wd_fail = 0;
    logic        done = 0;
    logic [31:0] snap_regs [32];
    logic [31:0] snap_pc;

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic summary();
        int tot, bad;
        tot = n_chk + mon_chk + wd_fail;
        bad = n_fail + mon_fail + wd_fail;
        $display("%0d/%0d checks passed", tot - bad, tot);
    endtask

    task automatic wait_state(input logic [2:0] s, input string req);
        for (int i = 0; i < 600; i++) begin
            if (ctrl_state == s) break;
            @(negedge clk);
        end
        chk(ctrl_state == s, req, 32'(ctrl_state), 32'(s));
    endtask

    task automatic check_image();
        int mm = 0;
        if (mem[0] != snap_pc) mm++;
        for (int i = 1; i < 32; i++) if (mem[i] != snap_regs[i]) mm++;
        chk(mm == 0, "R4 image mismatches", 32'(mm), 0);
        chk(mem[32] == MAGIC, "R4 commit word", mem[32], MAGIC);
    endtask

    task automatic check_core();
        int mm = 0;
        for (int i = 1; i < 32; i++) if (regs_m[i] != snap_regs[i]) mm++;
        chk(mm == 0, "R10 register mismatches", 32'(mm), 0);
        chk(pc_m == snap_pc, "R10 pc", pc_m, snap_pc);
    endtask

    task automatic do_round(input int r);
        bit bounce, corrupt;
        int d;
        bounce  = (r == 0) || (r > 2 && ($urandom % 4) == 0);
        corrupt = (r == 1) || (!bounce && r > 2 && ($urandom % 4) == 0);
        repeat (10 + $urandom % 30) @(negedge clk);
        energy_ok = 0;
        @(negedge clk); @(negedge clk);
        chk(ctrl_state == S_RUN, "R2 still RUN after 2 edges", 32'(ctrl_state), 32'(S_RUN));
        @(negedge clk);
        chk(ctrl_state == S_STALL, "R2 STALL after 3 edges", 32'(ctrl_state), 32'(S_STALL));
        chk(core_stall && core_clk_en, "R2 stall with clock on", {30'b0, core_stall, core_clk_en}, 32'd3);
        d = $urandom % 6;
        for (int k = 0; k < d; k++) begin
            @(negedge clk);
            chk(ctrl_state == S_STALL && !nv_req, "R3 wait for idle", {28'b0, nv_req, ctrl_state}, 32'(S_STALL));
        end
        core_idle = 1;
        @(negedge clk);
        chk(ctrl_state == S_SAVE, "R3 save after idle", 32'(ctrl_state), 32'(S_SAVE));
        core_idle = 0;
        snap_pc = pc_m;
        for (int i = 0; i < 32; i++) snap_regs[i] = regs_m[i];
        if (bounce) begin
            repeat (4) @(negedge clk);
            energy_ok = 1;
            wait_state(S_RESTORE, "R9 restore after bounce");
            chk(mem[32] == MAGIC, "R9 committed before restore", mem[32], MAGIC);
            check_image();
            wait_state(S_RUN, "R10 run after bounce");
            check_core();
        end else begin
            wait_state(S_GATED, "R6 gated after save");
            chk(!core_clk_en && core_stall, "R6 clock off", {30'b0, core_clk_en, core_stall}, 32'd1);
            check_image();
            scr_req = 1; @(negedge clk); scr_req = 0;
            if (corrupt) begin cor_req = 1; @(negedge clk); cor_req = 0; end
            repeat (4) @(negedge clk);
            chk(ctrl_state == S_GATED && !nv_req, "R6 stays gated", 32'(ctrl_state), 32'(S_GATED));
            energy_ok = 1;
            wait_state(S_RUN, "R10 run after resume");
            if (corrupt) begin
                chk(cold_seen, "R8 cold reset pulse", 32'(cold_seen), 1);
                chk(rd_total == 1, "R8 single read", rd_total, 1);
                chk(pc_m == 0, "R8 core cold pc", pc_m, 0);
            end else begin
                chk(!cold_seen, "R7 no cold reset", 32'(cold_seen), 0);
                chk(rd_total == 33, "R7 read count", rd_total, 33);
                check_core();
            end
        end
    endtask

    initial begin
        void'($urandom(32'd7351));
        energy_ok = 0; core_idle = 0; scr_req = 0; cor_req = 0; rst = 1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 0;
        chk(ctrl_state == S_GATED, "R1 reset state", 32'(ctrl_state), 32'(S_GATED));
        chk(!core_clk_en, "R1 clock off", 32'(core_clk_en), 0);
        chk(core_stall, "R1 stalled", 32'(core_stall), 1);
        chk(!nv_req, "R1 no request", 32'(nv_req), 0);
        repeat (6) @(negedge clk);
        chk(ctrl_state == S_GATED && !nv_req, "R1 idle without energy", 32'(ctrl_state), 32'(S_GATED));
        energy_ok = 1;
        wait_state(S_RUN, "R8 cold start to RUN");
        chk(cold_seen, "R8 cold start pulse", 32'(cold_seen), 1);
        chk(rd_total == 1, "R8 cold start reads", rd_total, 1);
        chk(!core_stall && core_clk_en, "R2 running", {30'b0, core_stall, core_clk_en}, 32'd1);
        for (int r = 0; r < 14; r++) do_round(r);
        done = 1;
        summary();
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            wd_fail = 1;
            $display("FAIL watchdog expired in state %0d, expected completion", ctrl_state);
            summary();
            $finish;
        end
    end
endmodule